// File: doc/BRIEF.md
# Double-Buffered Serial DAC Register Front End

This block is the digital front end of a serial-input digital-to-analog converter. A host shifts a code word in over a three-wire serial port (data, serial clock, active-low select). A level-sensitive, active-low load input lets the input buffer track the shift register, and the buffer keeps its last value once load is released. A separate update input moves the buffer into the DAC register on its rising edge. That register alone drives the parallel code to the converter core, so shifting and loading never disturb the output.

All serial and control pins are asynchronous to the system clock. Each one passes through a synchronizer, and edges are detected in the system clock domain. A serial data output carries the bits that leave the top of the shift register, so several devices can be daisy-chained. A reset, with a select input, sets both storage registers to zero or to mid-scale. Each time the DAC register is written, the block emits a one-cycle update strobe.

Top module: `dacfe_top`

## Requirements
- R1: While `rst` is high at a clock edge, the input buffer and the DAC register both clear to 0 if `rst_mid` is low. If `rst_mid` is high, both take mid-scale, where only the top bit is set (0x8000 at 16 bits). No update strobe is produced by reset.
- R2: While `cs_n` is low, each rising edge of `sclk` shifts `sdi` into the shift register, most significant bit first. After 16 edges the shift register holds the word as sent. `sclk` edges while `cs_n` is high leave the shift register unchanged.
- R3: While `load_n` is low, the input buffer follows the shift register. While `load_n` is high, the buffer holds its value, whatever is shifted in.
- R4: `dac_code` changes only when an update is taken (or on reset). Shifting and buffer loading leave it unchanged. A rising edge on `upd` copies the input buffer to `dac_code`.
- R5: If `load_n` is low when the `upd` rising edge arrives, `dac_code` takes the current shift register contents, which are the value passing through the transparent buffer.
- R6: On each falling edge of `sclk` while `cs_n` is low, `sdo` takes the shift register's most significant bit. While a second word is shifted in, `sdo` therefore replays the previous word, MSB first, one bit ahead of each rising edge.
- R7: `upd_pulse` is high for exactly one system clock cycle each time `dac_code` is written by an update, in the same cycle the new code appears. It never rises without a preceding `upd` rising edge.
- R8: A falling edge of `upd` has no effect: no strobe and no change of `dac_code`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rst_mid | input | 1 | Reset value select: 0 gives zero, 1 gives mid-scale |
| sclk | input | 1 | Serial clock, asynchronous |
| sdi | input | 1 | Serial data in |
| cs_n | input | 1 | Active-low serial select |
| load_n | input | 1 | Active-low, level-sensitive buffer load |
| upd | input | 1 | Update; rising edge writes the DAC register |
| sdo | output | 1 | Serial data out for daisy-chaining |
| dac_code | output | DATA_W | Code presented to the converter core |
| upd_pulse | output | 1 | One-cycle strobe when dac_code is written |

## Verification
A corrupted shift register shows up at `sdo` one serial clock after the corrupted bit reaches the top. It also shows up in `dac_code` after the next load and update. An input buffer that tracks while load is high, or misses tracking while load is low, is revealed only at the next update edge, as a code that differs from the scoreboard entry. A spurious write of the DAC register is visible at once, as a strobe with no queued expectation or as a code change between updates.

// File: rtl/dacfe_pkg.sv
package dacfe_pkg;

  // Synchronized view of the asynchronous pins.
  typedef struct packed {
    logic sdi;
    logic sclk;
    logic cs_n;
    logic load_n;
    logic upd;
  } pins_t;

  localparam int PINS_W = $bits(pins_t);

  // Idle levels applied during reset, so no false edge follows reset.
  localparam pins_t PINS_IDLE = '{sdi: 1'b0, sclk: 1'b0, cs_n: 1'b1,
                                  load_n: 1'b1, upd: 1'b0};

endpackage

// File: rtl/dacfe_sync.sv
module dacfe_sync #(
  parameter int              W       = 5,
  parameter int              STAGES  = 2,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [STAGES-1:0][W-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= RST_VAL;
    else     chain[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[s] <= RST_VAL;
      else     chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/dacfe_shift.sv
module dacfe_shift #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sclk_s,
  input  logic             sdi_s,
  input  logic             cs_n_s,
  output logic [WIDTH-1:0] sreg,
  output logic             sdo,
  output logic             shift_en
);

  logic sclk_q;
  logic sclk_rise;
  logic sclk_fall;

  always_ff @(posedge clk) begin
    if (rst) sclk_q <= 1'b0;
    else     sclk_q <= sclk_s;
  end

  assign sclk_rise = sclk_s & ~sclk_q;
  assign sclk_fall = ~sclk_s & sclk_q;
  assign shift_en  = sclk_rise & ~cs_n_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      sreg <= '0;
    end else if (shift_en) begin
      sreg <= {sreg[WIDTH-2:0], sdi_s};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sdo <= 1'b0;
    end else if (sclk_fall && !cs_n_s) begin
      sdo <= sreg[WIDTH-1];
    end
  end

endmodule

// File: rtl/dacfe_regs.sv
module dacfe_regs #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rst_mid,
  input  logic             load_n_s,
  input  logic             upd_s,
  input  logic [WIDTH-1:0] sreg,
  output logic [WIDTH-1:0] ibuf,
  output logic [WIDTH-1:0] dac_code,
  output logic             upd_pulse,
  output logic             upd_rise,
  output logic             load_low
);

  localparam logic [WIDTH-1:0] MID_CODE = {1'b1, {(WIDTH-1){1'b0}}};

  logic             upd_q;
  logic [WIDTH-1:0] rst_code;
  logic [WIDTH-1:0] next_code;

  assign rst_code  = rst_mid ? MID_CODE : '0;
  assign load_low  = ~load_n_s;
  assign upd_rise  = upd_s & ~upd_q;
  // Transparent buffer: with load active the update sees the live word.
  assign next_code = load_low ? sreg : ibuf;

  always_ff @(posedge clk) begin
    if (rst) upd_q <= 1'b0;
    else     upd_q <= upd_s;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ibuf <= rst_code;
    end else if (load_low) begin
      ibuf <= sreg;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dac_code  <= rst_code;
      upd_pulse <= 1'b0;
    end else begin
      upd_pulse <= upd_rise;
      if (upd_rise) dac_code <= next_code;
    end
  end

endmodule

// File: rtl/dacfe_top.sv
module dacfe_top #(
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rst_mid,
  input  logic              sclk,
  input  logic              sdi,
  input  logic              cs_n,
  input  logic              load_n,
  input  logic              upd,
  output logic              sdo,
  output logic [DATA_W-1:0] dac_code,
  output logic              upd_pulse
);

  import dacfe_pkg::*;

  pins_t              pins_raw;
  pins_t              pins_s;
  logic [DATA_W-1:0]  sreg;
  logic [DATA_W-1:0]  ibuf;
  logic               shift_en;
  logic               upd_rise;
  logic               load_low;

  assign pins_raw = '{sdi: sdi, sclk: sclk, cs_n: cs_n,
                      load_n: load_n, upd: upd};

  dacfe_sync #(
    .W       (PINS_W),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (PINS_IDLE)
  ) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pins_raw),
    .q   (pins_s)
  );

  dacfe_shift #(
    .WIDTH (DATA_W)
  ) u_shift (
    .clk      (clk),
    .rst      (rst),
    .sclk_s   (pins_s.sclk),
    .sdi_s    (pins_s.sdi),
    .cs_n_s   (pins_s.cs_n),
    .sreg     (sreg),
    .sdo      (sdo),
    .shift_en (shift_en)
  );

  dacfe_regs #(
    .WIDTH (DATA_W)
  ) u_regs (
    .clk       (clk),
    .rst       (rst),
    .rst_mid   (rst_mid),
    .load_n_s  (pins_s.load_n),
    .upd_s     (pins_s.upd),
    .sreg      (sreg),
    .ibuf      (ibuf),
    .dac_code  (dac_code),
    .upd_pulse (upd_pulse),
    .upd_rise  (upd_rise),
    .load_low  (load_low)
  );

endmodule

// File: rtl/dacfe_check.sv
module dacfe_check #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         rst_mid,
  input logic [W-1:0] dac_code,
  input logic         upd_pulse,
  input logic         upd_rise,
  input logic [W-1:0] ibuf,
  input logic         load_low,
  input logic [W-1:0] sreg,
  input logic         shift_en
);

  localparam logic [W-1:0] MID = {1'b1, {(W-1){1'b0}}};

  // R1: reset leaves the selected value in the DAC register
  a_r1_reset_value: assert property (@(posedge clk)
    rst |=> (dac_code == ($past(rst_mid) ? MID : '0)));

  // R2: shift register moves only on an enabled serial edge
  a_r2_shift_gate: assert property (@(posedge clk) disable iff (rst)
    !$stable(sreg) |-> ($past(shift_en) || $past(rst)));

  // R3: buffer holds while load is inactive
  a_r3_buf_hold: assert property (@(posedge clk) disable iff (rst)
    !$stable(ibuf) |-> ($past(load_low) || $past(rst)));

  // R4: output code changes only together with the strobe
  a_r4_code_stable: assert property (@(posedge clk) disable iff (rst)
    !$stable(dac_code) |-> (upd_pulse || $past(rst)));

  // R7: strobe lasts one cycle
  a_r7_pulse_single: assert property (@(posedge clk) disable iff (rst)
    upd_pulse |=> !upd_pulse);

  // R7: strobe always follows a detected update edge
  a_r7_pulse_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(upd_pulse) |-> $past(upd_rise));

endmodule

bind dacfe_top dacfe_check #(.W(DATA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .rst_mid   (rst_mid),
  .dac_code  (dac_code),
  .upd_pulse (upd_pulse),
  .upd_rise  (upd_rise),
  .ibuf      (ibuf),
  .load_low  (load_low),
  .sreg      (sreg),
  .shift_en  (shift_en)
);

// File: tb/dacfe_top_tb.sv
module dacfe_top_tb;

  localparam int W    = 16;
  localparam int HALF = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         rst_mid = 1'b0;
  logic         sclk = 1'b0;
  logic         sdi = 1'b0;
  logic         cs_n = 1'b1;
  logic         load_n = 1'b1;
  logic         upd = 1'b0;
  logic         sdo;
  logic [W-1:0] dac_code;
  logic         upd_pulse;

  int n_checks = 0;
  int n_fail   = 0;
  int pulse_cnt = 0;
  bit done = 0;
  logic [W-1:0] exp_q[$];
  logic [W-1:0] sdo_seen;

  always #2.5 clk = ~clk;

  dacfe_top #(.DATA_W(W), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst(rst), .rst_mid(rst_mid), .sclk(sclk), .sdi(sdi),
    .cs_n(cs_n), .load_n(load_n), .upd(upd), .sdo(sdo),
    .dac_code(dac_code), .upd_pulse(upd_pulse)
  );

  task automatic check(input bit ok, input string req,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Scoreboard monitor
  logic prev_pulse = 1'b0;
  always @(negedge clk) begin
    if (!rst && upd_pulse) begin
      pulse_cnt++;
      check(!prev_pulse, "R7 pulse width", 16'(prev_pulse), 16'h0);
      if (exp_q.size() == 0) begin
        check(1'b0, "R7 strobe without update", dac_code, 16'hxxxx);
      end else begin
        logic [W-1:0] e;
        e = exp_q.pop_front();
        check(dac_code == e, "R4 code on update", dac_code, e);
      end
    end
    prev_pulse = upd_pulse;
  end

  // Shift one word MSB first; record sdo ahead of every rising edge.
  task automatic send_word(input logic [W-1:0] w);
    for (int i = W - 1; i >= 0; i--) begin
      sdi = w[i];
      wait_cyc(HALF);
      sdo_seen[i] = sdo;
      sclk = 1'b1;
      wait_cyc(HALF);
      sclk = 1'b0;
    end
    wait_cyc(HALF);
  endtask

  task automatic do_load();
    load_n = 1'b0;
    wait_cyc(HALF);
    load_n = 1'b1;
    wait_cyc(HALF);
  endtask

  task automatic do_update(input logic [W-1:0] exp);
    int c0;
    exp_q.push_back(exp);
    upd = 1'b1;
    wait_cyc(HALF);
    check(exp_q.size() == 0, "R7 strobe issued", 16'(exp_q.size()), 16'h0);
    check(dac_code == exp, "R4 update value", dac_code, exp);
    c0 = pulse_cnt;
    upd = 1'b0;
    wait_cyc(HALF);
    check(pulse_cnt == c0, "R8 falling edge no strobe", 16'(pulse_cnt), 16'(c0));
    check(dac_code == exp, "R8 falling edge no change", dac_code, exp);
  endtask

  task automatic apply_reset(input logic mid);
    rst_mid = mid;
    rst = 1'b1;
    sclk = 1'b0; cs_n = 1'b1; load_n = 1'b1; upd = 1'b0; sdi = 1'b0;
    wait_cyc(4);
    rst = 1'b0;
    wait_cyc(4);
  endtask

  initial begin
    int c0;
    apply_reset(1'b0);
    check(dac_code == 16'h0000, "R1 zero reset", dac_code, 16'h0000);
    check(upd_pulse == 1'b0, "R1 no strobe", 16'(upd_pulse), 16'h0);
    check(sdo == 1'b0, "R1 sdo reset", 16'(sdo), 16'h0);

    apply_reset(1'b1);
    check(dac_code == 16'h8000, "R1 mid reset", dac_code, 16'h8000);
    do_update(16'h8000); // R1: buffer also at mid-scale

    cs_n = 1'b0;
    send_word(16'h1234);
    check(dac_code == 16'h8000, "R4 shift keeps code", dac_code, 16'h8000);
    do_load();
    check(dac_code == 16'h8000, "R4 load keeps code", dac_code, 16'h8000);
    do_update(16'h1234); // R2 MSB first, R3 load

    send_word(16'hBEEF);
    do_load();
    send_word(16'h5A5A);
    check(sdo_seen == 16'hBEEF, "R6 daisy output", sdo_seen, 16'hBEEF);
    do_update(16'hBEEF); // R3 buffer held while 5A5A shifted

    cs_n = 1'b1;
    send_word(16'hFFFF); // R2 ignored with select high
    cs_n = 1'b0;
    do_load();
    do_update(16'h5A5A);

    load_n = 1'b0;
    wait_cyc(HALF);
    send_word(16'h0F0F);
    do_update(16'h0F0F); // R5 transparent capture
    load_n = 1'b1;
    wait_cyc(HALF);

    c0 = pulse_cnt;
    send_word(16'h3C3C);
    do_load();
    check(pulse_cnt == c0, "R7 no strobe without update", 16'(pulse_cnt), 16'(c0));
    check(dac_code == 16'h0F0F, "R4 code held", dac_code, 16'h0F0F);

    apply_reset(1'b0);
    check(dac_code == 16'h0000, "R1 zero reset mid-run", dac_code, 16'h0000);
    cs_n = 1'b0;
    do_update(16'h0000); // R1: buffer cleared too

    wait_cyc(10);
    check(exp_q.size() == 0, "R7 queue drained", 16'(exp_q.size()), 16'h0);
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule